// File: doc/BRIEF.md
# Fractional Baud-Rate Tick Generator

This block turns a reference clock into the 16x-oversampling tick that a serial transmitter and receiver use. Software programs a 16-bit whole-number divisor and a 6-bit fraction in 1/64 steps. The tick period, measured in reference clocks, then averages whole + fraction/64. The serial bit rate is therefore refclk / (16 × (whole + fraction/64)), which equals refclk × 4 / (whole × 64 + fraction).

The fraction is realised by an accumulator. The accumulator gains 64 on every reference clock. When it reaches the combined target (whole × 64 + fraction), it emits a tick and keeps the excess, so individual periods are either whole or whole + 1 clocks and no error builds up over time. A whole divisor of zero halts the generator. The block keeps a working copy of the divisors and refreshes it from the programmed registers only at a tick boundary, or at any cycle while halted. A divide-by-16 counter marks every sixteenth tick as a bit-rate strobe.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, both divisor registers read zero and no tick is produced.
- R2: The whole divisor is read and written at word address 9 with all 16 bits. The fraction is at word address 10: only write bits [5:0] are kept, and a read returns them zero-extended, so the value never exceeds 63.
- R3: A write to any other word address changes no register, and a read from any other address returns zero.
- R4: While the working whole divisor is zero, tick_o and bit_stb_o stay low.
- R5: With fraction zero and whole divisor N ≥ 1, consecutive ticks are exactly N clocks apart. N = 1 gives a tick on every clock.
- R6: With fraction F, every tick interval is N or N+1 clocks, and any 64 consecutive intervals sum to exactly 64·N + F clocks.
- R7: Each tick is a single-clock pulse on tick_o. With N ≥ 2, tick_o is low in the clock after a tick.
- R8: bit_stb_o is high only together with tick_o, on the 16th, 32nd, … tick counted from leave of the halted state.
- R9: A divisor written while running takes effect only after the next tick. This includes a write of zero, which yields exactly one more tick before the halt.
- R10: When a halted generator receives a nonzero whole divisor with target T = 64·N + F, the first tick is seen ceil(T/64) clocks after the clock that ends the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Word address of the register access |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Combinational read data for reg_addr_i |
| tick_o | output | 1 | 16x oversampling tick, one clock wide |
| bit_stb_o | output | 1 | Bit-rate strobe on every 16th tick |

## Verification
The assertions assume that a register write is a single-clock strobe, with address and data valid in that clock. They also assume that the working divisor only changes when a tick occurs or while the generator is halted, since the deferred-update and accumulator-bound properties are built on that. The bench drives every access at the falling edge for exactly one clock. It halts the generator and waits out the longest period in use before each new divisor setting, so every scenario starts from a known zero accumulator and a zero bit counter.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  localparam int unsigned ADDR_WHOLE = 9;
  localparam int unsigned ADDR_FRAC  = 10;
endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import frac_baud_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [INT_W-1:0]  wdata_i,
  output logic [INT_W-1:0]  whole_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic [INT_W-1:0]  rdata_o
);
  localparam logic [ADDR_W-1:0] A_WHOLE = ADDR_W'(ADDR_WHOLE);
  localparam logic [ADDR_W-1:0] A_FRAC  = ADDR_W'(ADDR_FRAC);

  logic [INT_W-1:0]  whole_q;
  logic [FRAC_W-1:0] frac_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      whole_q <= '0;
      frac_q  <= '0;
    end else if (we_i) begin
      if (addr_i == A_WHOLE) whole_q <= wdata_i;
      if (addr_i == A_FRAC)  frac_q  <= wdata_i[FRAC_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_WHOLE)     rdata_o = whole_q;
    else if (addr_i == A_FRAC) rdata_o = {{(INT_W-FRAC_W){1'b0}}, frac_q};
  end

  assign whole_o = whole_q;
  assign frac_o  = frac_q;
endmodule

// File: rtl/baud_accum.sv
module baud_accum #(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [INT_W-1:0]        whole_i,
  input  logic [FRAC_W-1:0]       frac_i,
  output logic                    tick_o,
  output logic                    run_o,
  output logic [INT_W-1:0]        act_whole_o,
  output logic [INT_W+FRAC_W-1:0] acc_o,
  output logic [INT_W+FRAC_W-1:0] target_o
);
  localparam int unsigned ACC_W = INT_W + FRAC_W;
  localparam logic [ACC_W:0] STEP = (ACC_W+1)'(1) << FRAC_W;

  logic [INT_W-1:0]  act_whole_q;
  logic [FRAC_W-1:0] act_frac_q;
  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  target;
  logic [ACC_W:0]    sum;
  logic [ACC_W:0]    rem;
  logic              run;
  logic              hit;

  assign target = {act_whole_q, act_frac_q};
  assign sum    = {1'b0, acc_q} + STEP;
  assign rem    = sum - {1'b0, target};
  assign run    = |act_whole_q;
  assign hit    = run && (sum >= {1'b0, target});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_whole_q <= '0;
      act_frac_q  <= '0;
      acc_q       <= '0;
    end else if (!run) begin
      // halted: follow programmed values, restart from zero phase
      act_whole_q <= whole_i;
      act_frac_q  <= frac_i;
      acc_q       <= '0;
    end else if (hit) begin
      act_whole_q <= whole_i;
      act_frac_q  <= frac_i;
      acc_q       <= rem[ACC_W-1:0];
    end else begin
      acc_q       <= sum[ACC_W-1:0];
    end
  end

  assign tick_o      = hit;
  assign run_o       = run;
  assign act_whole_o = act_whole_q;
  assign acc_o       = acc_q;
  assign target_o    = target;
endmodule

// File: rtl/baud_bitdiv.sv
module baud_bitdiv #(
  parameter int unsigned OSR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic stb_o
);
  localparam int unsigned CNT_W = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (tick_i)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign stb_o = tick_i && (cnt_q == LAST);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 6,
  parameter int unsigned OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [INT_W-1:0]  reg_wdata_i,
  output logic [INT_W-1:0]  reg_rdata_o,
  output logic              tick_o,
  output logic              bit_stb_o
);
  localparam int unsigned ACC_W = INT_W + FRAC_W;

  logic [INT_W-1:0]  whole_q;
  logic [FRAC_W-1:0] frac_q;
  logic [INT_W-1:0]  act_whole;
  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  target;
  logic              run;
  logic              tick;

  baud_regs #(.ADDR_W(ADDR_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .whole_o (whole_q),
    .frac_o  (frac_q),
    .rdata_o (reg_rdata_o)
  );

  baud_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_accum (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .whole_i     (whole_q),
    .frac_i      (frac_q),
    .tick_o      (tick),
    .run_o       (run),
    .act_whole_o (act_whole),
    .acc_o       (acc),
    .target_o    (target)
  );

  baud_bitdiv #(.OSR(OSR)) u_bitdiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_i (tick),
    .stb_o  (bit_stb_o)
  );

  assign tick_o = tick;
endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 6
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    reg_we_i,
  input logic [ADDR_W-1:0]       reg_addr_i,
  input logic [INT_W-1:0]        reg_rdata_o,
  input logic                    tick_o,
  input logic                    bit_stb_o,
  input logic [INT_W-1:0]        act_whole,
  input logic [INT_W+FRAC_W-1:0] acc,
  input logic [INT_W+FRAC_W-1:0] target,
  input logic [INT_W-1:0]        whole_q
);
  localparam logic [INT_W-1:0] FRAC_LIM = INT_W'(1) << FRAC_W;

  assert_halt_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_whole == '0) |-> (!tick_o && !bit_stb_o));

  assert_acc_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_whole != '0) |-> (acc < target));

  assert_stb_on_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |-> tick_o);

  assert_defer_update_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((act_whole != '0) && !tick_o) |=> $stable(act_whole));

  assert_frac_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_W'(10)) |-> (reg_rdata_o < FRAC_LIM));

  assert_reg_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> $stable(whole_q));
endmodule

bind frac_baud_gen frac_baud_chk #(
  .ADDR_W(ADDR_W), .INT_W(INT_W), .FRAC_W(FRAC_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .tick_o      (tick_o),
  .bit_stb_o   (bit_stb_o),
  .act_whole   (act_whole),
  .acc         (acc),
  .target      (target),
  .whole_q     (whole_q)
);

// File: tb/tb_frac_baud_gen.sv
module tb_frac_baud_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        tick;
  logic        stb;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frac_baud_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tick_o(tick), .bit_stb_o(stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(input int a, input int d);
    @(negedge clk);
    we = 1'b1; addr = 5'(a); wdata = 16'(d);
    @(negedge clk);
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic do_read(input int a, output int d);
    @(negedge clk);
    addr = 5'(a);
    #1 d = int'(rdata);
  endtask

  task automatic wait_tick(output int c, output bit s);
    c = -1; s = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (tick) begin c = cyc; s = stb; break; end
    end
  endtask

  task automatic count_ticks(input int n, output int t);
    t = 0;
    for (int i = 0; i < n; i++) begin
      if (tick) t++;
      @(negedge clk);
    end
  endtask

  task automatic first_delay(output int n);
    n = -1;
    for (int i = 1; i < 2000; i++) begin
      @(negedge clk);
      if (tick) begin n = i; break; end
    end
  endtask

  task automatic halt_gen();
    do_write(9, 0);
    repeat (300) @(negedge clk);
  endtask

  task automatic t_reset();
    int d, t;
    do_read(9, d);  chk(d == 0, "R1 whole reset", d, 0);
    do_read(10, d); chk(d == 0, "R1 frac reset", d, 0);
    count_ticks(50, t); chk(t == 0, "R1 no tick after reset", t, 0);
  endtask

  task automatic t_regs();
    int d;
    do_write(10, 16'hFFFF);
    do_read(10, d); chk(d == 63, "R2 frac masked to 6 bits", d, 63);
    do_write(11, 16'h1234);
    do_read(9, d);  chk(d == 0, "R3 whole untouched", d, 0);
    do_read(10, d); chk(d == 63, "R3 frac untouched", d, 63);
    do_read(11, d); chk(d == 0, "R3 unmapped read zero", d, 0);
    do_write(10, 0);
  endtask

  task automatic t_halt();
    int t, s;
    s = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tick || stb) s++;
    end
    t = s;
    chk(t == 0, "R4 halted silent", t, 0);
  endtask

  task automatic t_whole();
    int n, d, c0, c1;
    bit s;
    do_write(9, 5);
    first_delay(n); chk(n == 5, "R10 first tick N=5", n, 5);
    c0 = cyc;
    do_read(9, d);  chk(d == 5, "R2 whole readback", d, 5);
    @(negedge clk);
    chk(tick == 1'b0, "R7 single-clock pulse", int'(tick), 0);
    wait_tick(c0, s);
    for (int k = 0; k < 10; k++) begin
      wait_tick(c1, s);
      chk(c1 - c0 == 5, "R5 interval N=5", c1 - c0, 5);
      c0 = c1;
    end
    halt_gen();
    do_write(9, 1);
    first_delay(n);
    for (int k = 0; k < 20; k++) begin
      chk(tick == 1'b1, "R5 tick every clock N=1", int'(tick), 1);
      @(negedge clk);
    end
    halt_gen();
  endtask

  task automatic t_frac();
    int n, c0, c1, sum, bad, sbad;
    bit s;
    do_write(10, 23);
    do_write(9, 5);
    first_delay(n); chk(n == 6, "R10 first tick T=343", n, 6);
    c0 = cyc;
    chk(stb == 1'b0, "R8 no strobe on tick 1", int'(stb), 0);
    sum = 0; bad = 0; sbad = 0;
    for (int k = 2; k <= 65; k++) begin
      wait_tick(c1, s);
      if (!(c1 - c0 == 5 || c1 - c0 == 6)) bad++;
      if (s != ((k % 16) == 0)) sbad++;
      if (k == 16) chk(s == 1'b1, "R8 strobe on tick 16", int'(s), 1);
      sum += c1 - c0;
      c0 = c1;
    end
    chk(bad == 0, "R6 intervals N or N+1", bad, 0);
    chk(sum == 343, "R6 64 intervals sum", sum, 343);
    chk(sbad == 0, "R8 strobe every 16th tick", sbad, 0);
    halt_gen();
    do_write(10, 0);
  endtask

  task automatic t_defer();
    int c0, c1, c2, t;
    bit s;
    do_write(9, 100);
    wait_tick(c0, s);
    repeat (10) @(negedge clk);
    do_write(9, 3);
    wait_tick(c1, s);
    chk(c1 - c0 == 100, "R9 old period kept", c1 - c0, 100);
    wait_tick(c2, s);
    chk(c2 - c1 == 3, "R9 new period after tick", c2 - c1, 3);
    do_write(9, 0);
    count_ticks(60, t);
    chk(t == 1, "R9 one tick before halt", t, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_halt();
    t_whole();
    t_frac();
    t_defer();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule